// File: doc/BRIEF.md
# Crosspoint Switch Programming Controller

This block is the digital control front end of an eight-output, eight-input video crosspoint. It receives programming traffic in one of two ways chosen by a strap. In serial mode a 32-bit shift register is clocked one bit per write strobe, and its top bit leaves on a serial output so that several controllers can be chained. In parallel mode each write strobe carries a 3-bit output address and a 4-bit nibble, which is either a routing value or a command.

The shift register and the parallel slots form one master register. A slave register holds the routing that is actually in force. A second strap picks how the master is moved to the slave. In edge mode the move happens on a rising edge of the latch pin. In level mode the slave tracks the master for as long as the latch pin is low. Some parallel commands act on the slave at once, and one command acts as a latch issued by software. The write and latch pins and both chip enables are asynchronous. Each passes through a two-flop synchroniser clocked by the system clock.

The writes are sequenced by a small state machine. `ST_IDLE` waits for an accepted write strobe. On one it moves to `ST_SHIFT` in serial mode. In parallel mode it moves to `ST_LOAD` for nibbles 0000 to 1000, to `ST_IMMED` for 1011 to 1110 and to `ST_SWLATCH` for 1111. For 1001 and 1010 it stays in `ST_IDLE`. Each execute state lasts one cycle, performs its update at the end of that cycle and returns to `ST_IDLE`.

Top module: `xpt_prog_ctrl`

## Requirements
- R1: A synchronous reset sets every master and slave field to 1000. After reset, out_en is all zero, out_sel is all zero and sdo is 1.
- R2: A write strobe is accepted only while ce_n is 0 and ce is 1. A rising edge on wr at any other time leaves the master register unchanged.
- R3: With ser_mode = 1, each accepted wr rising edge shifts the 32-bit master left and puts pdata[0] into bit 0. Field k occupies bits 4k+3..4k, and sdo always equals bit 31. pdata[3:1] have no effect in this mode.
- R4: With ser_mode = 0, an accepted write whose nibble is 0000 to 1000 stores the nibble in the master field selected by addr.
- R5: With edge_mode = 1, the slave copies the whole master once for each rising edge of latch and otherwise holds its value. A command in R8 or R7 can still change it.
- R6: With edge_mode = 0, the slave copies the master every cycle while latch is low and holds its value while latch is high.
- R7: Parallel nibble 1111 copies the whole master into the slave, whatever the state of edge_mode and latch.
- R8: Parallel nibbles 1011 to 1110 act at once, whatever the state of latch and edge_mode. 1011 sets field addr to 1000 in both registers. 1100 sets every field to 1000 in both registers. 1101 copies master field addr into slave field addr. 1110 sets every field of both registers to {0, addr}, which routes input addr to all outputs.
- R9: Parallel nibbles 1001 and 1010 change neither register.
- R10: For each output k, a slave field with bit 3 = 0 gives out_en[k] = 1 and out_sel[3k+2:3k] = field[2:0]. A slave field with bit 3 = 1 gives out_en[k] = 0 and out_sel for that output = 000.
- R11: A latch transfer and an R8 command can fall in the same cycle. The slave then takes the transfer first, from the master as it stood before that cycle. After that, the command's own slave values override the fields the command writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_mode | input | 1 | Strap: 1 selects serial programming, 0 selects parallel |
| edge_mode | input | 1 | Strap: 1 selects an edge-triggered slave load, 0 selects level transparency |
| wr | input | 1 | Asynchronous write strobe; acts on its rising edge |
| latch | input | 1 | Asynchronous slave transfer control |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| addr | input | 3 | Output address for parallel writes |
| pdata | input | 4 | Parallel nibble; bit 0 is also the serial data input |
| sdo | output | 1 | Serial output, the top bit of the master, for chaining |
| out_sel | output | 24 | Selected input index for each output, 3 bits per output |
| out_en | output | 8 | Enable for each output |

## Verification
An immediate command and an edge-mode latch transfer can both update the slave register in the same clock cycle. The bench provokes this by raising latch exactly one system clock after wr. This makes up for the one-cycle capture stage in the write path, so both updates land on the same edge. Beforehand the bench writes a master field that differs from the slave, so the transfer is visible. The result is judged against R11: the untouched fields show the pre-transfer master values and the commanded field shows 1000.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // width of one routing field; bit 3 set means output disabled
    localparam int FIELD_W = 4;
    localparam int SEL_W   = FIELD_W - 1;

    localparam logic [FIELD_W-1:0] CODE_OFF      = 4'b1000;
    localparam logic [FIELD_W-1:0] CODE_OFF_ONE  = 4'b1011;
    localparam logic [FIELD_W-1:0] CODE_OFF_ALL  = 4'b1100;
    localparam logic [FIELD_W-1:0] CODE_PASS_ONE = 4'b1101;
    localparam logic [FIELD_W-1:0] CODE_BCAST    = 4'b1110;
    localparam logic [FIELD_W-1:0] CODE_SWLATCH  = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LOAD,
        ST_IMMED,
        ST_SWLATCH
    } xpt_state_t;

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign level = stage_q[STAGES-1];
    assign rise  = stage_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/xpt_cmd_fsm.sv
module xpt_cmd_fsm
    import xpt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_mode,
    input  logic               wr_acc,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [FIELD_W-1:0] data_in,
    output xpt_state_t         state,
    output logic [ADDR_W-1:0]  cap_addr,
    output logic [FIELD_W-1:0] cap_code,
    output logic               cap_sdi,
    output logic               do_shift,
    output logic               do_load,
    output logic               do_imm,
    output logic               do_swl
);

    xpt_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state: classify an accepted write, execute for one cycle
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_acc) begin
                    if (ser_mode)                      state_d = ST_SHIFT;
                    else if (data_in <= CODE_OFF)      state_d = ST_LOAD;
                    else if (data_in == CODE_SWLATCH)  state_d = ST_SWLATCH;
                    else if (data_in >= CODE_OFF_ONE)  state_d = ST_IMMED;
                    else                               state_d = ST_IDLE;
                end
            end
            ST_SHIFT:   state_d = ST_IDLE;
            ST_LOAD:    state_d = ST_IDLE;
            ST_IMMED:   state_d = ST_IDLE;
            ST_SWLATCH: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // operand capture at the accepted strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
            cap_code <= '0;
            cap_sdi  <= 1'b0;
        end else if (state_q == ST_IDLE && wr_acc) begin
            cap_addr <= addr_in;
            cap_code <= data_in;
            cap_sdi  <= data_in[0];
        end
    end

    // outputs: one strobe per execute state
    always_comb begin
        do_shift = 1'b0;
        do_load  = 1'b0;
        do_imm   = 1'b0;
        do_swl   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SHIFT:   do_shift = 1'b1;
            ST_LOAD:    do_load  = 1'b1;
            ST_IMMED:   do_imm   = 1'b1;
            ST_SWLATCH: do_swl   = 1'b1;
            default:    ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/xpt_regfile.sv
module xpt_regfile
    import xpt_pkg::*;
#(
    parameter int N_OUT  = 8,
    parameter int ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       edge_mode,
    input  logic                       latch_lvl,
    input  logic                       latch_rise,
    input  logic                       do_shift,
    input  logic                       do_load,
    input  logic                       do_imm,
    input  logic                       do_swl,
    input  logic [ADDR_W-1:0]          cap_addr,
    input  logic [FIELD_W-1:0]         cap_code,
    input  logic                       cap_sdi,
    output logic [N_OUT*FIELD_W-1:0]   mst,
    output logic [N_OUT*FIELD_W-1:0]   slv
);

    localparam int TOT_W = N_OUT * FIELD_W;

    logic [TOT_W-1:0]   mst_d, slv_d, mst_shl;
    logic               xfer;
    logic               imm_off_all, imm_bcast;
    logic [FIELD_W-1:0] bcast_val;

    assign mst_shl     = {mst[TOT_W-2:0], cap_sdi};
    assign xfer        = do_swl | (edge_mode ? latch_rise : ~latch_lvl);
    assign imm_off_all = do_imm && (cap_code == CODE_OFF_ALL);
    assign imm_bcast   = do_imm && (cap_code == CODE_BCAST);
    assign bcast_val   = {1'b0, SEL_W'(cap_addr)};

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_field
            logic               hit, kill, pass;
            logic [FIELD_W-1:0] m_cur, s_cur, s_xfer;

            assign hit    = (cap_addr == ADDR_W'(k));
            assign kill   = imm_off_all || (do_imm && hit && cap_code == CODE_OFF_ONE);
            assign pass   = do_imm && hit && (cap_code == CODE_PASS_ONE);
            assign m_cur  = mst[k*FIELD_W +: FIELD_W];
            assign s_cur  = slv[k*FIELD_W +: FIELD_W];
            assign s_xfer = xfer ? m_cur : s_cur;

            // master: shift, slot load, or immediate command
            assign mst_d[k*FIELD_W +: FIELD_W] =
                do_shift          ? mst_shl[k*FIELD_W +: FIELD_W] :
                (do_load && hit)  ? cap_code :
                kill              ? CODE_OFF :
                imm_bcast         ? bcast_val :
                                    m_cur;

            // slave: transfer first, immediate command overrides
            assign slv_d[k*FIELD_W +: FIELD_W] =
                kill      ? CODE_OFF :
                imm_bcast ? bcast_val :
                pass      ? m_cur :
                            s_xfer;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mst <= {N_OUT{CODE_OFF}};
            slv <= {N_OUT{CODE_OFF}};
        end else begin
            mst <= mst_d;
            slv <= slv_d;
        end
    end

endmodule

// File: rtl/xpt_out_decode.sv
module xpt_out_decode
    import xpt_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic [N_OUT*FIELD_W-1:0] slv,
    output logic [N_OUT*SEL_W-1:0]   out_sel,
    output logic [N_OUT-1:0]         out_en
);

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_out
            logic off;
            assign off = slv[k*FIELD_W + FIELD_W - 1];
            assign out_en[k] = ~off;
            assign out_sel[k*SEL_W +: SEL_W] = off ? '0 : slv[k*FIELD_W +: SEL_W];
        end
    endgenerate

endmodule

// File: rtl/xpt_prog_ctrl.sv
module xpt_prog_ctrl
    import xpt_pkg::*;
#(
    parameter int N_OUT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_mode,
    input  logic                       edge_mode,
    input  logic                       wr,
    input  logic                       latch,
    input  logic                       ce_n,
    input  logic                       ce,
    input  logic [$clog2(N_OUT)-1:0]   addr,
    input  logic [FIELD_W-1:0]         pdata,
    output logic                       sdo,
    output logic [N_OUT*SEL_W-1:0]     out_sel,
    output logic [N_OUT-1:0]           out_en
);

    localparam int ADDR_W  = $clog2(N_OUT);
    localparam int TOT_W   = N_OUT * FIELD_W;
    localparam int N_PINS  = 4;
    localparam int IDX_WR  = 0;
    localparam int IDX_LAT = 1;
    localparam int IDX_CEN = 2;
    localparam int IDX_CE  = 3;

    logic [N_PINS-1:0]  pin_raw, pin_lvl, pin_rise;
    logic               wr_acc, latch_s, latch_rise;
    xpt_state_t         fsm_state;
    logic [ADDR_W-1:0]  cap_addr;
    logic [FIELD_W-1:0] cap_code;
    logic               cap_sdi, do_shift, do_load, do_imm, do_swl;
    logic [TOT_W-1:0]   mst_q, slv_q;

    assign pin_raw = {ce, ce_n, latch, wr};

    xpt_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_raw),
        .level    (pin_lvl),
        .rise     (pin_rise)
    );

    assign wr_acc     = pin_rise[IDX_WR] & pin_lvl[IDX_CE] & ~pin_lvl[IDX_CEN];
    assign latch_s    = pin_lvl[IDX_LAT];
    assign latch_rise = pin_rise[IDX_LAT];

    xpt_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ser_mode (ser_mode),
        .wr_acc   (wr_acc),
        .addr_in  (addr),
        .data_in  (pdata),
        .state    (fsm_state),
        .cap_addr (cap_addr),
        .cap_code (cap_code),
        .cap_sdi  (cap_sdi),
        .do_shift (do_shift),
        .do_load  (do_load),
        .do_imm   (do_imm),
        .do_swl   (do_swl)
    );

    xpt_regfile #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .edge_mode  (edge_mode),
        .latch_lvl  (latch_s),
        .latch_rise (latch_rise),
        .do_shift   (do_shift),
        .do_load    (do_load),
        .do_imm     (do_imm),
        .do_swl     (do_swl),
        .cap_addr   (cap_addr),
        .cap_code   (cap_code),
        .cap_sdi    (cap_sdi),
        .mst        (mst_q),
        .slv        (slv_q)
    );

    xpt_out_decode #(.N_OUT(N_OUT)) u_dec (
        .slv     (slv_q),
        .out_sel (out_sel),
        .out_en  (out_en)
    );

    assign sdo = mst_q[TOT_W-1];

endmodule

// File: rtl/xpt_prog_ctrl_chk.sv
module xpt_prog_ctrl_chk
    import xpt_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     edge_mode,
    input logic [N_OUT-1:0]         out_en,
    input xpt_state_t               state,
    input logic                     latch_lvl,
    input logic                     latch_rise,
    input logic [N_OUT*FIELD_W-1:0] mst,
    input logic [N_OUT*FIELD_W-1:0] slv
);

    localparam int TOT_W = N_OUT * FIELD_W;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (out_en == '0));

    p_idle_master_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> $stable(mst));

    p_shift_chain_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT) |=> (mst[TOT_W-1:1] == $past(mst[TOT_W-2:0])));

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && !latch_rise &&
         (state == ST_IDLE || state == ST_SHIFT || state == ST_LOAD))
        |=> $stable(slv));

    p_level_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && !latch_lvl && state != ST_IMMED)
        |=> (slv == $past(mst)));

    p_level_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && latch_lvl &&
         (state == ST_IDLE || state == ST_SHIFT || state == ST_LOAD))
        |=> $stable(slv));

    p_soft_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SWLATCH) |=> (slv == $past(mst)));

endmodule

bind xpt_prog_ctrl xpt_prog_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .edge_mode  (edge_mode),
    .out_en     (out_en),
    .state      (fsm_state),
    .latch_lvl  (latch_s),
    .latch_rise (latch_rise),
    .mst        (mst_q),
    .slv        (slv_q)
);

// File: tb/xpt_prog_ctrl_test.sv
module xpt_prog_ctrl_test;

    logic        clk = 1'b0;
    logic        rst, ser_mode, edge_mode, wr, latch, ce_n, ce;
    logic [2:0]  addr;
    logic [3:0]  pdata;
    logic        sdo;
    logic [23:0] out_sel;
    logic [7:0]  out_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] em, es;   // expected master and slave

    always #10 clk = ~clk; // 50 MHz

    xpt_prog_ctrl uut (
        .clk(clk), .rst(rst), .ser_mode(ser_mode), .edge_mode(edge_mode),
        .wr(wr), .latch(latch), .ce_n(ce_n), .ce(ce), .addr(addr),
        .pdata(pdata), .sdo(sdo), .out_sel(out_sel), .out_en(out_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        logic [7:0]  e_en;
        logic [23:0] e_sel;
        for (int k = 0; k < 8; k++) begin
            e_en[k]        = ~es[k*4+3];
            e_sel[k*3 +: 3] = es[k*4+3] ? 3'b000 : es[k*4 +: 3];
        end
        check(req, {32'd0, out_en, out_sel}, {32'd0, e_en, e_sel});
    endtask

    // expected-state updates taken from the requirements
    task automatic m_write(input int a, input logic [3:0] c);
        case (c)
            4'b1011: begin em[a*4 +: 4] = 4'h8; es[a*4 +: 4] = 4'h8; end
            4'b1100: begin em = {8{4'h8}}; es = em; end
            4'b1101: es[a*4 +: 4] = em[a*4 +: 4];
            4'b1110: begin em = {8{1'b0, a[2:0]}}; es = em; end
            4'b1111: es = em;
            4'b1001, 4'b1010: ;
            default: em[a*4 +: 4] = c;
        endcase
    endtask

    task automatic wr_pulse(input int a, input logic [3:0] d);
        @(negedge clk);
        addr = a[2:0]; pdata = d; wr = 1'b1;
        repeat (3) @(negedge clk);
        wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic latch_pulse();
        @(negedge clk);
        latch = 1'b1;
        repeat (3) @(negedge clk);
        latch = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 out_en", {56'd0, out_en}, 64'd0);
        check("R1 out_sel", {40'd0, out_sel}, 64'd0);
        check("R1 sdo", {63'd0, sdo}, 64'd1);
    endtask

    task automatic t_edge_parallel();
        wr_pulse(3, 4'd5); m_write(3, 4'd5);
        check_out("R5 no latch yet");
        latch_pulse(); es = em;
        check_out("R4/R5/R10 after latch");
        wr_pulse(7, 4'd7); m_write(7, 4'd7);
        wr_pulse(0, 4'd0); m_write(0, 4'd0);
        latch_pulse(); es = em;
        check_out("R4/R10 two slots");
        wr_pulse(3, 4'b1000); m_write(3, 4'b1000);
        latch_pulse(); es = em;
        check_out("R10 disable code");
    endtask

    task automatic t_chip_enable();
        @(negedge clk); ce_n = 1'b1;
        repeat (4) @(negedge clk);
        wr_pulse(1, 4'd2);
        latch_pulse(); es = em;
        check_out("R2 ce_n high");
        @(negedge clk); ce_n = 1'b0; ce = 1'b0;
        repeat (4) @(negedge clk);
        wr_pulse(1, 4'd2);
        latch_pulse(); es = em;
        check_out("R2 ce low");
        @(negedge clk); ce = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ignored();
        wr_pulse(2, 4'b1001); m_write(2, 4'b1001);
        wr_pulse(2, 4'b1010); m_write(2, 4'b1010);
        latch_pulse(); es = em;
        check_out("R9 codes 1001/1010");
    endtask

    task automatic t_soft_latch();
        wr_pulse(2, 4'd4); m_write(2, 4'd4);
        check_out("R5 held before soft latch");
        wr_pulse(0, 4'b1111); m_write(0, 4'b1111);
        check_out("R7 soft latch");
    endtask

    task automatic t_immediate();
        wr_pulse(2, 4'b1011); m_write(2, 4'b1011);
        check_out("R8 off one");
        wr_pulse(0, 4'b1100); m_write(0, 4'b1100);
        check_out("R8 off all");
        wr_pulse(6, 4'b1110); m_write(6, 4'b1110);
        check_out("R8 broadcast");
        wr_pulse(0, 4'd3); m_write(0, 4'd3);
        wr_pulse(0, 4'b1101); m_write(0, 4'b1101);
        check_out("R8 pass one");
    endtask

    task automatic t_collide();
        wr_pulse(4, 4'd1); m_write(4, 4'd1);
        // latch one clock after wr so both updates hit the same edge
        @(negedge clk);
        addr = 3'd1; pdata = 4'b1011; wr = 1'b1;
        @(negedge clk);
        latch = 1'b1;
        repeat (3) @(negedge clk);
        wr = 1'b0; latch = 1'b0;
        repeat (4) @(negedge clk);
        es = em;                 // transfer from the old master
        m_write(1, 4'b1011);     // then the command overrides
        check_out("R11 command beats transfer");
    endtask

    task automatic t_serial();
        logic [31:0] pat = 32'h3A8F_5162;
        @(negedge clk); ser_mode = 1'b1;
        for (int i = 31; i >= 0; i--) begin
            wr_pulse(0, {i[2:0] ^ 3'b101, pat[i]});
            em = {em[30:0], pat[i]};
            check("R3 sdo", {63'd0, sdo}, {63'd0, em[31]});
        end
        check_out("R3 outputs untouched before latch");
        latch_pulse(); es = em;
        check_out("R3/R5/R10 serial load");
    endtask

    task automatic t_level();
        @(negedge clk); latch = 1'b1;   // rising edge in edge mode
        repeat (4) @(negedge clk);
        es = em;
        edge_mode = 1'b0; ser_mode = 1'b0;
        repeat (2) @(negedge clk);
        wr_pulse(5, 4'd1); m_write(5, 4'd1);
        check_out("R6 hold while latch high");
        @(negedge clk); latch = 1'b0;
        repeat (5) @(negedge clk);
        es = em;
        check_out("R6 transparent after latch low");
        wr_pulse(4, 4'd2); m_write(4, 4'd2); es = em;
        check_out("R6 follows while latch low");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ser_mode = 1'b0; edge_mode = 1'b1; wr = 1'b0; latch = 1'b0;
        ce_n = 1'b0; ce = 1'b1; addr = 3'd0; pdata = 4'd0;
        em = {8{4'h8}}; es = em;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_edge_parallel();
        t_chip_enable();
        t_ignored();
        t_soft_latch();
        t_immediate();
        t_collide();
        t_serial();
        t_level();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule